// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block models the column-burst part of a single-bank synchronous DRAM. A command input selects NOP, READ or WRITE. The column address given with the command starts a fixed-length burst. Write beats are captured from a 32-bit input bus into a small internal array. Read beats are returned on a 32-bit output bus, with an output-enable flag, after a fixed number of internal cycles.

A clock-enable input is registered on every rising edge. When the registered value is LOW, the next internal edge does not happen. On that edge commands and write data are ignored, the output bus and its enable keep their values, and the beat and latency counting stop. Operation resumes on the edge after the input is registered HIGH again.

Command timing is set by the burst protocol itself, so the data pins have no valid/ready handshake. Back-pressure is given only through the clock-enable input, which stalls both directions together. Row handling, refresh, power states, mode programming and multiple banks are not modelled.

Top module: `sdram_burst_core`

## Requirements
- R1: While reset is held, and after it is released, `dq_oe` is 0, `dq_out` is 0 and the engine is idle.
- R2: A WRITE (`cmd`=2'b10) accepted while idle stores `dq_in` at the command edge and at each of the next BL-1 internal edges (BL=4). The column for beat i is the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL, so the burst wraps inside the aligned group of BL columns.
- R3: A READ (`cmd`=2'b01) accepted while idle puts beat 0 on `dq_out` after the internal edge that comes CL internal edges after the command edge (CL=2). Each following internal edge gives the next beat, using the same column order as R2.
- R4: `dq_oe` rises together with read beat 0 and stays 1 for BL+1 internal cycles. During the last of those cycles `dq_out` keeps the final beat. `dq_oe` is never 1 outside a read burst.
- R5: A LOW `cke` sampled at rising edge n suppresses internal edge n+1. A HIGH sample lets the next edge act, so `cke` takes effect with one cycle of latency.
- R6: On a suppressed edge, `dq_out` and `dq_oe` hold their values and the beat counter does not advance. Suppressed edges do not count toward the read latency.
- R7: On a suppressed edge during a write burst, `dq_in` is ignored. The pending beat is captured on the next internal edge that is not suppressed.
- R8: A command on a suppressed edge is ignored, including when the engine is idle and `cke` is held LOW. `cmd`=2'b00 and 2'b11 are both treated as NOP.
- R9: Commands that arrive during an active burst are ignored. A new command is accepted on the first internal edge after the last write beat, or after the edge on which `dq_oe` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, registered; LOW suppresses the next internal edge |
| cmd | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 NOP |
| col_addr | input | COL_W (6) | Start column, sampled with READ or WRITE |
| dq_in | input | DW (32) | Write beat data |
| dq_out | output | DW (32) | Read beat data |
| dq_oe | output | 1 | High while read data is driven |

## Verification
Two functions can fall in the same cycle: clock suspension and the end of a burst. Here that means a suppressed edge that lands on the final read beat or on the extra `dq_oe` cycle, or a suppressed edge on the first beat after a command. The bench provokes these with per-edge `cke` masks and drives illegal commands and garbage data on every edge it expects to be ignored. Each output sample is judged against a count of internal edges that the bench keeps from the `cke` values it drove. Stored data is then read back to confirm that no ignored write reached the array.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } burst_cmd_e;
endpackage

// File: rtl/sbc_cke_gate.sv
// Registers the clock enable; its output decides whether the next edge acts.
module sbc_cke_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic int_en
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign int_en = cke_q;
endmodule

// File: rtl/sbc_burst_seq.sv
// Burst sequencer: accepts commands, counts internal edges, forms columns.
module sbc_burst_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int BL    = 4,
  parameter int CL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_en,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col_addr,
  output logic             mem_we,
  output logic [COL_W-1:0] mem_waddr,
  output logic [COL_W-1:0] mem_raddr,
  output logic             rd_load,
  output logic             oe_clr,
  output logic             busy,
  output logic             is_rd,
  output logic [15:0]      beat_view
);
  localparam int BW    = $clog2(BL);
  localparam int CNT_W = $clog2(CL + BL + 2);
  localparam logic [CNT_W-1:0] RD_FIRST = CNT_W'(CL);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(CL + BL - 1);
  localparam logic [CNT_W-1:0] RD_END   = CNT_W'(CL + BL + 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(BL - 1);

  logic [COL_W-1:0] base_col;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             acc_rd;
  logic             acc_wr;
  logic [BW-1:0]    wr_idx;
  logic [BW-1:0]    rd_idx;

  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] start,
                                                input logic [BW-1:0] idx);
    logic [COL_W-1:0] r;
    r = start;
    r[BW-1:0] = start[BW-1:0] + idx;
    return r;
  endfunction

  assign acc_rd = (cmd == CMD_READ);
  assign acc_wr = (cmd == CMD_WRITE);
  assign accept = int_en && !busy && (acc_rd || acc_wr);

  // write path: beat 0 at the command edge, later beats from the counter
  assign wr_idx    = accept ? '0 : BW'(cnt);
  assign mem_waddr = wrap_col(accept ? col_addr : base_col, wr_idx);
  assign mem_we    = int_en && ((accept && acc_wr) || (busy && !is_rd));

  // read path: beats leave CL internal edges after the command
  assign rd_idx    = BW'(cnt - RD_FIRST);
  assign mem_raddr = wrap_col(base_col, rd_idx);
  assign rd_load   = int_en && busy && is_rd && (cnt >= RD_FIRST) && (cnt <= RD_LAST);
  assign oe_clr    = int_en && busy && is_rd && (cnt == RD_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_rd    <= 1'b0;
      base_col <= '0;
      cnt      <= '0;
    end else if (int_en) begin
      if (accept) begin
        busy     <= acc_rd || (BL > 1);
        is_rd    <= acc_rd;
        base_col <= col_addr;
        cnt      <= CNT_W'(1);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (!is_rd && cnt == WR_LAST) busy <= 1'b0;
        if (is_rd && cnt == RD_END)   busy <= 1'b0;
      end
    end
  end

  assign beat_view = 16'(cnt);
endmodule

// File: rtl/sbc_store.sv
// Column storage: one synchronous write port, one combinational read port.
module sbc_store #(
  parameter int COL_W = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [COL_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [COL_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << COL_W;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sbc_dq_drive.sv
// Output data register and output enable; both freeze on suppressed edges.
module sbc_dq_drive #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_en,
  input  logic          load,
  input  logic          clr,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else if (int_en) begin
      if (load) begin
        dq_out <= rdata;
        dq_oe  <= 1'b1;
      end else if (clr) begin
        dq_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core #(
  parameter int COL_W = 6,
  parameter int DW    = 32,
  parameter int BL    = 4,
  parameter int CL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  logic             int_en;
  logic             mem_we;
  logic [COL_W-1:0] mem_waddr;
  logic [COL_W-1:0] mem_raddr;
  logic [DW-1:0]    mem_rdata;
  logic             rd_load;
  logic             oe_clr;
  logic             seq_busy;
  logic             seq_is_rd;
  logic [15:0]      beat_view;

  sbc_cke_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .int_en (int_en)
  );

  sbc_burst_seq #(.COL_W(COL_W), .BL(BL), .CL(CL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_en    (int_en),
    .cmd       (cmd),
    .col_addr  (col_addr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_raddr (mem_raddr),
    .rd_load   (rd_load),
    .oe_clr    (oe_clr),
    .busy      (seq_busy),
    .is_rd     (seq_is_rd),
    .beat_view (beat_view)
  );

  sbc_store #(.COL_W(COL_W), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (dq_in),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  sbc_dq_drive #(.DW(DW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .int_en (int_en),
    .load   (rd_load),
    .clr    (oe_clr),
    .rdata  (mem_rdata),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );
endmodule

// File: rtl/sdram_burst_core_chk.sv
module sdram_burst_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          seq_busy,
  input logic          seq_is_rd,
  input logic          mem_we,
  input logic [15:0]   beat_view
);
  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 ($stable(dq_out) && $stable(dq_oe)));

  // R5
  beat_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 $stable(beat_view));

  // R4
  oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (seq_busy && seq_is_rd));

  // R2
  write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !dq_oe);
endmodule

bind sdram_burst_core sdram_burst_core_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .seq_busy  (seq_busy),
  .seq_is_rd (seq_is_rd),
  .mem_we    (mem_we),
  .beat_view (beat_view)
);

// File: tb/sdram_burst_core_tb_top.sv
module sdram_burst_core_tb_top;
  localparam int COL_W = 6;
  localparam int DW    = 32;
  localparam int BL    = 4;
  localparam int CL    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cke;
  logic [1:0]       cmd;
  logic [COL_W-1:0] col_addr;
  logic [DW-1:0]    dq_in;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [DW-1:0] ref_mem [64];

  always #4 clk = ~clk;

  sdram_burst_core #(.COL_W(COL_W), .DW(DW), .BL(BL), .CL(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd),
    .col_addr(col_addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // column of beat i: low two bits wrap inside the aligned group of four
  function automatic logic [COL_W-1:0] colw(input logic [COL_W-1:0] s, input int i);
    logic [COL_W-1:0] r;
    r = s;
    r[1:0] = s[1:0] + 2'(i);
    return r;
  endfunction

  function automatic logic [DW-1:0] beat(input logic [DW-1:0] seed, input int b);
    return seed ^ (32'h0101_0101 * (b + 1));
  endfunction

  function automatic bit mbit(input logic [31:0] m, input int j);
    return (j >= 0 && j < 32) ? m[j] : 1'b0;
  endfunction

  // mask bit j = 1 drives cke LOW before edge j
  task automatic run_write(input logic [COL_W-1:0] col, input logic [DW-1:0] seed,
                           input logic [31:0] mask);
    int b = 0;
    int j = 0;
    bit en;
    while (b < BL) begin
      en       = (j == 0) ? 1'b1 : !mbit(mask, j - 1);
      cmd      = (j == 0) ? 2'b10 : ((j % 2) != 0 ? 2'b01 : 2'b11);
      col_addr = (j == 0) ? col : ~col;
      cke      = !mbit(mask, j);
      dq_in    = en ? beat(seed, b) : (32'hDEAD_0000 | 32'(j));
      if (en) begin
        ref_mem[colw(col, b)] = beat(seed, b);
        b++;
      end
      tick();
      j++;
    end
    cmd = 2'b00;
    if (!cke) begin
      cke = 1'b1;
      tick();
    end
  endtask

  task automatic run_read(input logic [COL_W-1:0] col, input logic [31:0] mask,
                          input string tag);
    int j = 0;
    int k = 0;
    bit done = 0;
    bit en;
    bit exp_oe;
    logic [DW-1:0] exp_d;
    while (!done) begin
      cmd      = (j == 0) ? 2'b01 : 2'b10;
      col_addr = (j == 0) ? col : col + 6'd1;
      dq_in    = 32'hBAD0_0000 | 32'(j);
      cke      = !mbit(mask, j);
      tick();
      en = (j == 0) ? 1'b1 : !mbit(mask, j - 1);
      if (j > 0 && en) k++;
      exp_oe = (k >= CL) && (k <= CL + BL);
      check(dq_oe == exp_oe, {tag, " dq_oe"}, 32'(dq_oe), 32'(exp_oe));
      if (exp_oe) begin
        exp_d = (k < CL + BL) ? ref_mem[colw(col, k - CL)] : ref_mem[colw(col, BL - 1)];
        check(dq_out == exp_d, {tag, " dq_out"}, dq_out, exp_d);
      end
      if (k == CL + BL + 1) done = 1;
      j++;
    end
    cmd = 2'b00;
    if (!cke) begin
      cke = 1'b1;
      tick();
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0; cke = 1'b1; cmd = 2'b00; col_addr = '0; dq_in = '0;
    repeat (3) tick();
    check(dq_oe == 1'b0, "R1 oe in reset", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    tick();
    check(dq_oe == 1'b0, "R1 oe after reset", 32'(dq_oe), 32'd0);
    check(dq_out == '0, "R1 dq_out after reset", dq_out, '0);
  endtask

  // R2 R3 R4: plain write then read, aligned start
  task automatic t_plain();
    run_write(6'd8, 32'hA5A5_0000, 32'd0);
    run_read(6'd8, 32'd0, "R3 R4 plain");
  endtask

  // R2 R3: wrap inside the aligned group (13,14,15,12) and read from 14
  task automatic t_wrap();
    run_write(6'd13, 32'h3C3C_1000, 32'd0);
    run_read(6'd14, 32'd0, "R2 R3 wrap");
  endtask

  // R5 R6: suspension at the first latency edge, mid burst, and on the trailing oe cycle
  task automatic t_read_suspend();
    run_read(6'd13, 32'b0000_0001, "R5 first edge");
    run_read(6'd8,  32'b0001_1000, "R6 mid burst");
    run_read(6'd14, 32'b0110_0000, "R6 last beat");
    run_read(6'd8,  32'b1100_0000, "R6 trailing oe");
  endtask

  // R7: write beats presented again after suppressed edges
  task automatic t_write_suspend();
    run_write(6'd20, 32'h7E00_0077, 32'b0000_0110);
    run_read(6'd20, 32'd0, "R7 write resume");
    run_write(6'd33, 32'h1234_5678, 32'b0000_0101);
    run_read(6'd32, 32'b0000_0010, "R7 write resume2");
  endtask

  // R8: commands while idle with cke LOW are ignored
  task automatic t_idle_cke();
    cke = 1'b0; cmd = 2'b00;
    tick();
    cmd = 2'b10; col_addr = 6'd8; dq_in = 32'hFFFF_FFFF;
    tick();
    cmd = 2'b01;
    tick();
    cmd = 2'b10;
    tick();
    cmd = 2'b00; cke = 1'b1;
    tick();
    repeat (CL + 1) begin
      tick();
      check(dq_oe == 1'b0, "R8 no read started", 32'(dq_oe), 32'd0);
    end
    run_read(6'd8, 32'd0, "R8 data unchanged");
  endtask

  // R9: back-to-back commands, and bursts ignore commands while active
  task automatic t_back2back();
    run_write(6'd40, 32'h0F0F_4000, 32'd0);
    run_read(6'd40, 32'd0, "R9 read right after write");
    run_read(6'd41, 32'd0, "R9 read right after read");
    run_read(6'd13, 32'd0, "R9 junk writes ignored");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_wrap();
    t_read_suspend();
    t_write_suspend();
    t_idle_cke();
    t_back2back();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule